// File: doc/BRIEF.md
# Three-Word Packet Validator and Forwarder

This block watches a stream of 32-bit words, each qualified by a valid strobe, and finds its own packets in it. A packet is three words on consecutive valid cycles: a start word that carries a start code in its low three bits, a payload word with no code, and a closing word. The closing word holds a closing code in its top three bits, a source and a destination address of ten bits each, a six-bit hop counter, and three data bits at the bottom. While it waits for a packet, the block discards every word that does not begin one.

A packet is forwarded only when both codes are correct and its hop counter does not exceed a configured limit. A forwarded packet leaves on a 32-bit output with its own valid strobe. It takes three consecutive cycles and its hop counter is raised by one. A packet that fails a check, or that is cut short by a gap in the valid strobe, is dropped without a trace. The block then goes back to hunting for the next start word.

Neither side has a ready signal. The source cannot be stalled, and the sink must take one word on every cycle in which the output strobe is high. This costs nothing, because the output drains three words in the three cycles the next packet needs to arrive. Back-to-back packets therefore stream through with no loss.

Top module: `pkt_validator`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0.
- R2: While hunting, a word is ignored if in_valid is 0 or if its bits [2:0] differ from 3'b101. This includes a zero word strobed before a start word, and every word of a packet whose start code is wrong. No output results from such words.
- R3: A packet is accepted when its start word has bits [2:0] = 3'b101, the next two cycles carry valid words, the closing word has bits [31:29] = 3'b010, and its hop field (bits [8:3]) is at most MAX_HOPS. An accepted packet drives out_valid high for exactly three consecutive cycles. The first of these is the cycle after the closing word is sampled.
- R4: The three output words are, in order, the start word unchanged, the payload word unchanged, and the closing word with its hop field (bits [8:3]) raised by one and all other bits unchanged.
- R5: A closing word whose bits [31:29] are not 3'b010 causes the whole packet to be dropped with no output word.
- R6: A hop field greater than MAX_HOPS drops the packet. A hop field equal to MAX_HOPS is forwarded, with the hop field set to MAX_HOPS+1.
- R7: If in_valid is 0 in the cycle where a payload or closing word is due, the partial packet is discarded and produces no output. A start word that follows begins a fresh packet.
- R8: A start word may arrive in the cycle right after an accepted closing word. Both packets are then forwarded, with out_valid high for six consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Incoming stream word |
| in_valid | input | 1 | Marks in_data as a word of the stream |
| out_data | output | 32 | Forwarded word; zero when out_valid is 0 |
| out_valid | output | 1 | Marks out_data as a forwarded word |

## Verification
The bench builds the block with the default MAX_HOPS of 15. With that value both sides of the hop boundary fall inside the six-bit field: 15 is forwarded as 16, while 16 and 21 are dropped. Random hop values up to 63 reach far past the limit. Directed runs cover the stray zero word before a start word, gaps after the start word and after the payload word, and three packets sent back to back. Several hundred random packets of mixed health, with random gaps and random non-start filler, then exercise the hunting logic.

// File: rtl/pkt_pkg.sv
`timescale 1ns/1ps
package pkt_pkg;
  localparam int WORD_W    = 32;
  localparam int CODE_W    = 3;
  localparam int HOP_W     = 6;
  localparam int HOP_LSB   = 3;
  localparam int N_WORDS   = 3;
  localparam logic [CODE_W-1:0] START_CODE = 3'b101;
  localparam logic [CODE_W-1:0] CLOSE_CODE = 3'b010;

  typedef enum logic [1:0] {
    FR_HUNT    = 2'd0,
    FR_GOT_HDR = 2'd1,
    FR_GOT_PAY = 2'd2
  } frame_state_e;

  function automatic logic [CODE_W-1:0] start_code_of(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] close_code_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: CODE_W];
  endfunction

  function automatic logic [HOP_W-1:0] hop_of(input logic [WORD_W-1:0] w);
    return w[HOP_LSB +: HOP_W];
  endfunction
endpackage

// File: rtl/pkt_close_check.sv
`timescale 1ns/1ps
module pkt_close_check
  import pkt_pkg::*;
#(
  parameter int MAX_HOPS = 15
) (
  input  logic [WORD_W-1:0] close_word,
  output logic              close_ok,
  output logic [WORD_W-1:0] close_fwd
);
  localparam logic [HOP_W-1:0] HOP_LIMIT = HOP_W'(MAX_HOPS);

  logic [HOP_W-1:0] hop_in;
  logic             code_ok;
  logic             hop_ok;

  always_comb begin
    hop_in   = hop_of(close_word);
    code_ok  = (close_code_of(close_word) == CLOSE_CODE);
    hop_ok   = (hop_in <= HOP_LIMIT);
    close_ok = code_ok && hop_ok;
    close_fwd = close_word;
    close_fwd[HOP_LSB +: HOP_W] = hop_in + HOP_W'(1);
  end
endmodule

// File: rtl/pkt_framer.sv
`timescale 1ns/1ps
module pkt_framer
  import pkt_pkg::*;
#(
  parameter int MAX_HOPS = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WORD_W-1:0]         in_data,
  input  logic                      in_valid,
  output logic                      pkt_accept,
  output logic [N_WORDS*WORD_W-1:0] pkt_words
);
  frame_state_e      state_q;
  logic [WORD_W-1:0] head_q;
  logic [WORD_W-1:0] body_q;
  logic              close_ok;
  logic [WORD_W-1:0] close_fwd;
  logic              is_start;

  pkt_close_check #(.MAX_HOPS(MAX_HOPS)) u_close (
    .close_word (in_data),
    .close_ok   (close_ok),
    .close_fwd  (close_fwd)
  );

  assign is_start   = in_valid && (start_code_of(in_data) == START_CODE);
  assign pkt_accept = (state_q == FR_GOT_PAY) && in_valid && close_ok;
  assign pkt_words  = {close_fwd, body_q, head_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_HUNT;
      head_q  <= '0;
      body_q  <= '0;
    end else begin
      unique case (state_q)
        FR_HUNT: begin
          if (is_start) begin
            head_q  <= in_data;
            state_q <= FR_GOT_HDR;
          end
        end
        FR_GOT_HDR: begin
          if (in_valid) begin
            body_q  <= in_data;
            state_q <= FR_GOT_PAY;
          end else begin
            state_q <= FR_HUNT;
          end
        end
        FR_GOT_PAY: begin
          state_q <= FR_HUNT;
        end
        default: state_q <= FR_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pkt_out_seq.sv
`timescale 1ns/1ps
module pkt_out_seq #(
  parameter int W      = 32,
  parameter int NWORDS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NWORDS*W-1:0] words,
  output logic [W-1:0]        out_data,
  output logic                out_valid
);
  localparam int CNT_W = $clog2(NWORDS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NWORDS);

  logic [W-1:0]     slot_q [NWORDS];
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (load)             left_q <= FULL;
    else if (left_q != '0)     left_q <= left_q - CNT_W'(1);
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_slot
    if (i == NWORDS - 1) begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            slot_q[i] <= '0;
        else if (load)         slot_q[i] <= words[i*W +: W];
        else if (left_q != '0) slot_q[i] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            slot_q[i] <= '0;
        else if (load)         slot_q[i] <= words[i*W +: W];
        else if (left_q != '0) slot_q[i] <= slot_q[i+1];
      end
    end
  end

  assign out_valid = (left_q != '0);
  assign out_data  = out_valid ? slot_q[0] : '0;
endmodule

// File: rtl/pkt_validator.sv
`timescale 1ns/1ps
module pkt_validator
  import pkt_pkg::*;
#(
  parameter int MAX_HOPS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);
  logic                      pkt_accept;
  logic [N_WORDS*WORD_W-1:0] pkt_words;

  pkt_framer #(.MAX_HOPS(MAX_HOPS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .pkt_accept (pkt_accept),
    .pkt_words  (pkt_words)
  );

  pkt_out_seq #(.W(WORD_W), .NWORDS(N_WORDS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pkt_accept),
    .words     (pkt_words),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/pkt_validator_chk.sv
`timescale 1ns/1ps
module pkt_validator_chk
  import pkt_pkg::*;
#(
  parameter int MAX_HOPS = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] in_data,
  input logic              in_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3
  burst_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);

  // R3
  burst_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> ##1 out_valid);

  // R7
  gap_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !$rose(out_valid));

  // R4
  first_word_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (start_code_of(out_data) == START_CODE));

  // R5
  last_word_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> ##1 (close_code_of(out_data) == CLOSE_CODE));

  // R6
  last_word_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> ##1 (hop_of(out_data) >= HOP_W'(1) &&
                              hop_of(out_data) <= HOP_W'(MAX_HOPS + 1)));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
endmodule

bind pkt_validator pkt_validator_chk #(.MAX_HOPS(MAX_HOPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/test_pkt_validator.sv
`timescale 1ns/1ps
module test_pkt_validator;
  localparam int MAX_HOPS = 15;
  localparam int NCYC     = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;

  pkt_validator #(.MAX_HOPS(MAX_HOPS)) i_pkt_validator (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          exp_v   [NCYC];
  logic [31:0] exp_d   [NCYC];
  string       exp_tag [NCYC];
  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // cycle-exact monitor: compares against the expectation table
  always @(negedge clk) begin
    if (mon_on && cyc < NCYC) begin
      check(out_valid == exp_v[cyc], exp_tag[cyc], 32'(out_valid), 32'(exp_v[cyc]));
      if (exp_v[cyc] && out_valid)
        check(out_data == exp_d[cyc], "R4", out_data, exp_d[cyc]);
    end
  end

  function automatic logic [31:0] mk_close(logic [2:0] code, logic [9:0] src,
      logic [9:0] dst, logic [5:0] hop, logic [2:0] low);
    return {code, src, dst, hop, low};
  endfunction

  function automatic bool_ok(logic [2:0] hc, logic [2:0] tc, logic [5:0] hop);
    return (hc == 3'b101) && (tc == 3'b010) && (int'(hop) <= MAX_HOPS);
  endfunction

  task automatic put(logic [31:0] w, bit v);
    in_data  = w;
    in_valid = v;
    @(negedge clk);
  endtask

  task automatic tag_after(int t, string tag);
    for (int k = 1; k <= 3; k++)
      if (t + k < NCYC && !exp_v[t+k]) exp_tag[t+k] = tag;
  endtask

  // drive one packet; the expectation comes from R3..R6
  task automatic send_pkt(logic [2:0] hc, logic [28:0] hdata, logic [31:0] body,
      logic [2:0] tc, logic [9:0] src, logic [9:0] dst, logic [5:0] hop,
      logic [2:0] low);
    logic [31:0] h, tl;
    int t;
    h  = {hdata, hc};
    tl = mk_close(tc, src, dst, hop, low);
    put(h, 1'b1);
    put(body, 1'b1);
    t = cyc;
    put(tl, 1'b1);
    if (bool_ok(hc, tc, hop)) begin
      if (t + 3 < NCYC) begin
        exp_v[t+1] = 1'b1; exp_d[t+1] = h;    exp_tag[t+1] = "R3";
        exp_v[t+2] = 1'b1; exp_d[t+2] = body; exp_tag[t+2] = "R3";
        exp_v[t+3] = 1'b1; exp_d[t+3] = mk_close(tc, src, dst, hop + 6'd1, low);
        exp_tag[t+3] = "R3";
      end
    end else if (hc != 3'b101) tag_after(t, "R2");
    else if (tc != 3'b010)     tag_after(t, "R5");
    else                       tag_after(t, "R6");
  endtask

  function automatic logic [31:0] filler();
    logic [31:0] w;
    w = $urandom;
    if (w[2:0] == 3'b101) w[2:0] = 3'b100;
    return w;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCYC; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R2";
    end
    @(negedge clk);
    // R1: outputs quiet under reset
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    put('0, 1'b0);

    // R2: stray zero word before a start word, then a healthy packet (R3, R4)
    put('0, 1'b1);
    send_pkt(3'b101, 29'd123, 32'd321, 3'b010, 10'd98, 10'd99, 6'd5, 3'b101);
    repeat (5) put('0, 1'b0);

    // R2: wrong start code, payload and closing word carry no start code
    send_pkt(3'b111, 29'd1234, 32'd3210, 3'b010, 10'd980, 10'd990, 6'd8, 3'b000);
    repeat (5) put('0, 1'b0);

    // R5: wrong closing code
    send_pkt(3'b101, 29'd1234, 32'd3210, 3'b000, 10'd980, 10'd990, 6'd9, 3'b101);
    repeat (5) put('0, 1'b0);

    // R6: too many hops, one past the limit, exactly the limit, zero
    send_pkt(3'b101, 29'd7, 32'd8, 3'b010, 10'd1, 10'd2, 6'd21, 3'b001);
    repeat (4) put('0, 1'b0);
    send_pkt(3'b101, 29'd9, 32'd10, 3'b010, 10'd3, 10'd4, 6'(MAX_HOPS + 1), 3'b010);
    repeat (4) put('0, 1'b0);
    send_pkt(3'b101, 29'd11, 32'hFFFF_FFFF, 3'b010, 10'h3FF, 10'h3FF, 6'(MAX_HOPS), 3'b111);
    repeat (4) put('0, 1'b0);
    send_pkt(3'b101, 29'h1FFF_FFFF, 32'd0, 3'b010, 10'd0, 10'd0, 6'd0, 3'b000);
    repeat (4) put('0, 1'b0);

    // R7: gap after the start word, then after the payload word
    begin
      int t;
      put({29'd55, 3'b101}, 1'b1);
      t = cyc;
      put('0, 1'b0);
      tag_after(t, "R7");
      put(32'h0000_0010, 1'b1);
      put(32'h4000_0028, 1'b1);
      send_pkt(3'b101, 29'd66, 32'd77, 3'b010, 10'd5, 10'd6, 6'd2, 3'b011);
      put({29'd88, 3'b101}, 1'b1);
      put(32'd99, 1'b1);
      t = cyc;
      put('0, 1'b0);
      tag_after(t, "R7");
      put(mk_close(3'b010, 10'd1, 10'd1, 6'd1, 3'b000), 1'b1);
      repeat (4) put('0, 1'b0);
    end

    // R8: three healthy packets back to back
    for (int p = 0; p < 3; p++)
      send_pkt(3'b101, 29'($urandom), $urandom, 3'b010, 10'($urandom),
               10'($urandom), 6'(p * 4), 3'($urandom));
    repeat (5) put('0, 1'b0);

    // random mix of healthy and broken packets with gaps and filler
    for (int n = 0; n < 400; n++) begin
      logic [2:0] hc, tc, low;
      logic [5:0] hop;
      logic [31:0] body;
      int kind, gap;
      kind = $urandom_range(0, 9);
      hc   = 3'b101;
      tc   = 3'b010;
      hop  = 6'($urandom_range(0, MAX_HOPS));
      body = $urandom;
      low  = 3'($urandom);
      if (kind == 6) begin
        hc = 3'($urandom);
        if (hc == 3'b101) hc = 3'b001;
        if (body[2:0] == 3'b101) body[2:0] = 3'b000;
        if (low == 3'b101) low = 3'b000;
      end else if (kind == 7) begin
        tc = 3'($urandom);
        if (tc == 3'b010) tc = 3'b110;
      end else if (kind >= 8) begin
        hop = 6'($urandom_range(MAX_HOPS + 1, 63));
      end
      send_pkt(hc, 29'($urandom), body, tc, 10'($urandom), 10'($urandom), hop, low);
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        if ($urandom_range(0, 1) == 1) put(filler(), 1'b1);
        else                           put($urandom, 1'b0);
      end
    end
    repeat (6) put('0, 1'b0);
    mon_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule